// File: doc/BRIEF.md
# Synthesizer Serial Programming Sequencer

This block programs a frequency synthesizer over a three-wire serial control port: a serial clock, a data line and a latch strobe. It also drives the synthesizer's chip-enable pin and watches its lock-detect pin. After reset it raises chip enable. It then writes four 24-bit configuration words in a fixed order: initialization, function, reference divider and feedback divider. The configuration values come from input ports. The two lowest bits of each word carry the destination latch code, and the sequencer forces those bits itself.

Each word goes out most significant bit first, in one frame of 24 bits (three bytes) inside a low pulse of the latch strobe. The target captures data on the rising serial clock edge, so the data line only moves while the serial clock is low. The rising latch edge commits the word. Once the fourth word is committed, the block reports `done` and starts watching lock detect through a synchronizer. If lock is not seen within a set number of cycles, it raises a sticky error.

After power-up, single-word updates enter through a valid/ready port. A word moves on a cycle in which `upd_valid` and `upd_ready` are both high. `upd_ready` stays low until the power-up sequence has finished, and again for the whole frame of any accepted update, so a producer holds its word and valid until it sees ready. Update words are sent verbatim, latch code included. The serial clock is the system clock divided by `2*HALF_DIV`. A setting that would exceed 20 MHz is rejected at elaboration.

Top module: `synth_prog_seq`

## Requirements
- R1: While reset is held: `ser_clk`=0, `ser_latch`=1, `ser_data`=0, `chip_en`=0, and `done`, `locked`, `lock_err` and `upd_ready` are all 0.
- R2: `chip_en` is high before the first falling edge of `ser_latch` and stays high from then on.
- R3: The four power-up frames carry, in order, `{cfg_init[23:2],2'b11}`, `{cfg_func[23:2],2'b10}`, `{cfg_rdiv[23:2],2'b00}` and `{cfg_ndiv[23:2],2'b01}`.
- R4: Each frame has these steps, in order:
  - `ser_latch` falls.
  - `ser_clk` gives exactly 24 rising edges, with `ser_data` sampled MSB first.
  - `ser_latch` rises after the last bit.
  - `ser_clk` is low whenever `ser_latch` is high.
- R5: `ser_data` changes only while `ser_clk` is low. Each high phase of `ser_clk` lasts exactly `HALF_DIV` system cycles.
- R6: Between frames, `ser_latch` stays high for at least `2*HALF_DIV` system cycles.
- R7: `upd_ready` is 0 until `done` is 1. A request held valid during power-up is not sent before the fourth frame.
- R8: After `done`, a handshake sends `upd_word` unchanged as one frame. During that frame `busy`=1 and `upd_ready`=0, and a second valid request waits for it to end.
- R9: `done` rises once the fourth frame has ended and then stays high. `busy` is 0 whenever no frame is pending or in progress after `done`.
- R10: `locked` follows the synchronized lock-detect input, 3 cycles late, but only once `done` is high. It is 0 before that.
- R11: `lock_err` becomes 1, and stays 1, if lock detect is not seen within `LOCK_TIMEOUT` cycles after `done`. It stays 0 if lock is seen within that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_init | input | 24 | Initialization word (bits 1:0 replaced) |
| cfg_func | input | 24 | Function word (bits 1:0 replaced) |
| cfg_rdiv | input | 24 | Reference divider word (bits 1:0 replaced) |
| cfg_ndiv | input | 24 | Feedback divider word (bits 1:0 replaced) |
| upd_valid | input | 1 | Update word offered |
| upd_ready | output | 1 | Update word can be taken this cycle |
| upd_word | input | 24 | Update word, sent verbatim |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data, MSB first |
| ser_latch | output | 1 | Latch strobe, low during a frame |
| chip_en | output | 1 | Synthesizer power enable |
| lock_det | input | 1 | Asynchronous lock-detect input |
| busy | output | 1 | Power-up or an update frame in progress |
| done | output | 1 | Power-up sequence complete |
| locked | output | 1 | Lock detected after power-up |
| lock_err | output | 1 | Lock timeout, sticky |

## Verification
A bench-side decoder rebuilds each frame from the serial pins alone. It also checks phase lengths, data stability and latch gaps.

Power-up is run with configuration words whose low bits all differ from the codes that must be forced, which exposes any missing or swapped code. An update is held valid throughout power-up, which tells hold-off apart from early acceptance. Two back-to-back updates, whose low bits are not forced, tell a verbatim send from a forced one.

One run keeps lock detect low and another holds it high from reset. Together they separate a timeout from a lock report, and a lock reported early from one reported after `done`.

// File: rtl/synprog_pkg.sv
`timescale 1ns/1ps
package synprog_pkg;
  localparam int WORD_W = 24;
  localparam int NUM_INIT = 4;
  localparam int IDX_W = $clog2(NUM_INIT);

  typedef enum logic [2:0] {
    ST_PWR, ST_SEND, ST_WAIT, ST_RUN, ST_UPD
  } seq_state_e;

  // destination latch code placed in bits 1:0 for each power-up step
  function automatic logic [1:0] step_code(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd0:    return 2'b11;
      2'd1:    return 2'b10;
      2'd2:    return 2'b00;
      default: return 2'b01;
    endcase
  endfunction
endpackage

// File: rtl/synprog_tick.sv
`timescale 1ns/1ps
module synprog_tick #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  generate
    if (DIV == 1) begin : g_pass
      assign tick = en;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      assign tick = en && (cnt == CW'(DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!en)    cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/synprog_shifter.sv
`timescale 1ns/1ps
module synprog_shifter #(
  parameter int W = 24,
  parameter int HALF_DIV = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] word,
  output logic         idle,
  output logic         fin,
  output logic         sclk,
  output logic         sdata,
  output logic         slatch
);
  // half-period steps: 0 latch low, odd = clock high, even = clock low,
  // 2W last low, 2W+1 latch up, 2W+2..2W+3 latch-high gap
  localparam int STEPS   = 2 * W + 4;
  localparam int SW      = $clog2(STEPS + 1);
  localparam int CLK_END = 2 * W;
  localparam int LE_UP   = 2 * W + 1;
  localparam int LAST    = STEPS - 1;

  logic          active;
  logic          tick;
  logic [SW-1:0] step;
  logic [SW-1:0] nxt;
  logic [W-1:0]  sh;

  assign idle = !active;
  assign nxt  = step + 1'b1;

  synprog_tick #(.DIV(HALF_DIV)) u_tick (
    .clk (clk),
    .rst_n (rst_n),
    .en (active),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= '0;
      sh     <= '0;
      fin    <= 1'b0;
      sclk   <= 1'b0;
      sdata  <= 1'b0;
      slatch <= 1'b1;
    end else begin
      fin <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          step   <= '0;
          sh     <= word;
          sdata  <= word[W-1];
          sclk   <= 1'b0;
          slatch <= 1'b0;
        end
      end else if (tick) begin
        if (step == SW'(LAST)) begin
          active <= 1'b0;
          step   <= '0;
          fin    <= 1'b1;
        end else begin
          step <= nxt;
          if (nxt <= SW'(CLK_END)) begin
            if (nxt[0]) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (nxt != SW'(CLK_END)) begin
                sh    <= {sh[W-2:0], 1'b0};
                sdata <= sh[W-2];
              end
            end
          end else if (nxt == SW'(LE_UP)) begin
            slatch <= 1'b1;
            sdata  <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/synprog_lock_mon.sv
`timescale 1ns/1ps
module synprog_lock_mon #(
  parameter int TIMEOUT = 100000,
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic lock_raw,
  output logic locked,
  output logic timed_out
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [SYNC-1:0] sync_q;
  logic            lock_s;
  logic            seen;
  logic [CW-1:0]   cnt;

  generate
    if (SYNC < 2) begin : g_bad_sync
      $error("lock synchronizer needs at least two stages");
    end
  endgenerate

  assign lock_s = sync_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC-2:0], lock_raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      timed_out <= 1'b0;
      seen      <= 1'b0;
      cnt       <= '0;
    end else begin
      locked <= arm && lock_s;
      if (arm && !seen) begin
        if (lock_s)                         seen      <= 1'b1;
        else if (cnt == CW'(TIMEOUT - 1))   timed_out <= 1'b1;
        else                                cnt       <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/synth_prog_seq.sv
`timescale 1ns/1ps
module synth_prog_seq #(
  parameter int unsigned CLK_HZ = 200_000_000,
  parameter int HALF_DIV = 5,
  parameter int LOCK_TIMEOUT = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] cfg_init,
  input  logic [23:0] cfg_func,
  input  logic [23:0] cfg_rdiv,
  input  logic [23:0] cfg_ndiv,
  input  logic        upd_valid,
  output logic        upd_ready,
  input  logic [23:0] upd_word,
  output logic        ser_clk,
  output logic        ser_data,
  output logic        ser_latch,
  output logic        chip_en,
  input  logic        lock_det,
  output logic        busy,
  output logic        done,
  output logic        locked,
  output logic        lock_err
);
  import synprog_pkg::*;

  localparam longint unsigned SCLK_HZ  = longint'(CLK_HZ) / longint'(2 * HALF_DIV);
  localparam longint unsigned SCLK_MAX = 20_000_000;

  generate
    if (HALF_DIV < 1 || SCLK_HZ > SCLK_MAX) begin : g_bad_div
      $error("serial clock divider gives a rate above 20 MHz");
    end
  endgenerate

  seq_state_e         state;
  logic [IDX_W-1:0]   idx;
  logic [WORD_W-1:0]  cfg_sel;
  logic [WORD_W-1:0]  tx_word;
  logic               tx_start;
  logic               tx_idle;
  logic               tx_fin;
  logic               accept;

  always_comb begin
    case (idx)
      2'd0:    cfg_sel = cfg_init;
      2'd1:    cfg_sel = cfg_func;
      2'd2:    cfg_sel = cfg_rdiv;
      default: cfg_sel = cfg_ndiv;
    endcase
  end

  assign upd_ready = (state == ST_RUN) && tx_idle;
  assign accept    = upd_valid && upd_ready;
  assign tx_start  = (state == ST_SEND) || accept;
  assign tx_word   = (state == ST_RUN) ? upd_word
                                       : {cfg_sel[WORD_W-1:2], step_code(idx)};
  assign busy      = (state != ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_PWR;
      idx     <= '0;
      chip_en <= 1'b0;
      done    <= 1'b0;
    end else begin
      case (state)
        ST_PWR: begin
          chip_en <= 1'b1;
          state   <= ST_SEND;
        end
        ST_SEND: state <= ST_WAIT;
        ST_WAIT: begin
          if (tx_fin) begin
            if (idx == IDX_W'(NUM_INIT - 1)) begin
              state <= ST_RUN;
              done  <= 1'b1;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_SEND;
            end
          end
        end
        ST_RUN: if (accept) state <= ST_UPD;
        ST_UPD: if (tx_fin) state <= ST_RUN;
        default: state <= ST_PWR;
      endcase
    end
  end

  synprog_shifter #(.W(WORD_W), .HALF_DIV(HALF_DIV)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tx_start),
    .word   (tx_word),
    .idle   (tx_idle),
    .fin    (tx_fin),
    .sclk   (ser_clk),
    .sdata  (ser_data),
    .slatch (ser_latch)
  );

  synprog_lock_mon #(.TIMEOUT(LOCK_TIMEOUT), .SYNC(SYNC_STAGES)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (done),
    .lock_raw  (lock_det),
    .locked    (locked),
    .timed_out (lock_err)
  );
endmodule

// File: rtl/synth_prog_seq_chk.sv
`timescale 1ns/1ps
module synth_prog_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic upd_ready,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_latch,
  input logic chip_en,
  input logic busy,
  input logic done,
  input logic locked,
  input logic lock_err
);
  assert_clk_low_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_latch |-> !ser_clk);

  assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  assert_enable_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_latch |-> chip_en);

  assert_ready_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !upd_ready);

  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ready |-> !busy);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_lock_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> done);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |=> lock_err);
endmodule

bind synth_prog_seq synth_prog_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_ready (upd_ready),
  .ser_clk   (ser_clk),
  .ser_data  (ser_data),
  .ser_latch (ser_latch),
  .chip_en   (chip_en),
  .busy      (busy),
  .done      (done),
  .locked    (locked),
  .lock_err  (lock_err)
);

// File: tb/tb_synth_prog_seq.sv
`timescale 1ns/1ps
module tb_synth_prog_seq;
  localparam int HALF = 5;
  localparam int LOCK_TO = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [23:0] cfg_init, cfg_func, cfg_rdiv, cfg_ndiv, upd_word;
  logic upd_valid, upd_ready, ser_clk, ser_data, ser_latch, chip_en;
  logic lock_det, busy, done, locked, lock_err;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  synth_prog_seq #(.HALF_DIV(HALF), .LOCK_TIMEOUT(LOCK_TO)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .cfg_func(cfg_func),
    .cfg_rdiv(cfg_rdiv), .cfg_ndiv(cfg_ndiv), .upd_valid(upd_valid),
    .upd_ready(upd_ready), .upd_word(upd_word), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_latch(ser_latch), .chip_en(chip_en),
    .lock_det(lock_det), .busy(busy), .done(done), .locked(locked),
    .lock_err(lock_err)
  );

  // serial-pin decoder
  logic [23:0] words [0:15];
  logic [23:0] fw;
  int nwords, fbits, hi_cnt, gap_cnt, cyc, done_cyc;
  int bad_len, bad_hi, bad_stab, bad_gap, bad_ce, bad_ready;
  logic p_clk, p_le, p_sd, p_done;

  always @(negedge clk) begin
    if (!rst_n) begin
      nwords = 0; fbits = 0; hi_cnt = 0; gap_cnt = 0; cyc = 0; done_cyc = 0;
      bad_len = 0; bad_hi = 0; bad_stab = 0; bad_gap = 0; bad_ce = 0; bad_ready = 0;
      p_clk = ser_clk; p_le = ser_latch; p_sd = ser_data; p_done = 0; fw = 0;
    end else begin
      cyc++;
      if (done && !p_done) done_cyc = cyc;
      if (upd_ready && !done) bad_ready++;
      if (p_le && !ser_latch) begin
        fbits = 0; fw = 0;
        if (!chip_en) bad_ce++;
        if (nwords > 0 && gap_cnt < 2 * HALF) bad_gap++;
      end
      if (!p_clk && ser_clk) begin
        fw = {fw[22:0], ser_data}; fbits++; hi_cnt = 1;
      end else if (ser_clk) hi_cnt++;
      if (p_clk && !ser_clk && hi_cnt != HALF) bad_hi++;
      if (p_clk && ser_clk && ser_data != p_sd) bad_stab++;
      if (!p_le && ser_latch) begin
        if (fbits != 24) bad_len++;
        if (nwords < 16) words[nwords] = fw;
        nwords++; gap_cnt = 1;
      end else if (ser_latch) gap_cnt++;
      p_clk = ser_clk; p_le = ser_latch; p_sd = ser_data; p_done = done;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step_n(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && !done; i++) step_n(1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) step_n(1);
  endtask

  task automatic t_reset(input logic lk, input logic hold);
    rst_n = 0; lock_det = lk; upd_valid = hold; upd_word = 24'h5A5A5A;
    cfg_init = 24'hA5C300; cfg_func = 24'h123457;
    cfg_rdiv = 24'h00FFFF; cfg_ndiv = 24'h3C0002;
    step_n(4);
    chk(!ser_clk && ser_latch && !ser_data, "R1 serial idle", {ser_clk, ser_latch, ser_data}, 3'b010);
    chk(!chip_en && !done && !locked && !lock_err && !upd_ready, "R1 status idle",
        {chip_en, done, locked, lock_err, upd_ready}, 0);
    rst_n = 1;
  endtask

  task automatic t_powerup();
    wait_done();
    chk(done, "R9 done reached", done, 1);
    chk(nwords == 4, "R7 held request not sent early", nwords, 4);
    chk(!busy, "R9 busy low at done", busy, 0);
    chk(words[0] == {cfg_init[23:2], 2'b11}, "R3 word0", words[0], {cfg_init[23:2], 2'b11});
    chk(words[1] == {cfg_func[23:2], 2'b10}, "R3 word1", words[1], {cfg_func[23:2], 2'b10});
    chk(words[2] == {cfg_rdiv[23:2], 2'b00}, "R3 word2", words[2], {cfg_rdiv[23:2], 2'b00});
    chk(words[3] == {cfg_ndiv[23:2], 2'b01}, "R3 word3", words[3], {cfg_ndiv[23:2], 2'b01});
    step_n(1);
    upd_valid = 0;
    chk(busy && !upd_ready, "R8 busy after accept", {busy, upd_ready}, 2'b10);
  endtask

  task automatic t_timeout();
    while (cyc < done_cyc + LOCK_TO - 10) step_n(1);
    chk(!lock_err, "R11 no error before timeout", lock_err, 0);
    while (cyc < done_cyc + LOCK_TO + 10) step_n(1);
    chk(lock_err, "R11 error after timeout", lock_err, 1);
    chk(!locked, "R10 not locked without detect", locked, 0);
    wait_idle();
    chk(nwords == 5 && words[4] == 24'h5A5A5A, "R8 held word sent verbatim", words[4], 24'h5A5A5A);
  endtask

  task automatic t_update();
    int held_ok = 1;
    upd_word = 24'hDEADBE; upd_valid = 1;
    for (int i = 0; i < 50 && !upd_ready; i++) step_n(1);
    step_n(1);
    upd_word = 24'h000001;
    while (busy) begin
      if (upd_ready) held_ok = 0;
      step_n(1);
    end
    chk(held_ok == 1 && nwords == 6, "R8 second request waits", nwords, 6);
    step_n(1);
    upd_valid = 0;
    wait_idle();
    chk(nwords == 7, "R8 two frames", nwords, 7);
    chk(words[5] == 24'hDEADBE, "R8 first update", words[5], 24'hDEADBE);
    chk(words[6] == 24'h000001, "R8 second update", words[6], 24'h000001);
  endtask

  task automatic t_timing();
    step_n(2 * HALF);
    chk(bad_len == 0, "R4 24 bits per frame", bad_len, 0);
    chk(bad_hi == 0, "R5 high phase length", bad_hi, 0);
    chk(bad_stab == 0, "R5 data stable while high", bad_stab, 0);
    chk(bad_gap == 0, "R6 latch gap", bad_gap, 0);
    chk(bad_ce == 0 && chip_en, "R2 chip enable", bad_ce, 0);
    chk(bad_ready == 0, "R7 ready before done", bad_ready, 0);
    chk(!ser_clk && ser_latch, "R4 idle levels", {ser_clk, ser_latch}, 2'b01);
  endtask

  task automatic t_lockpath();
    while (nwords < 2) step_n(1);
    chk(!locked && !done, "R10 no lock before done", locked, 0);
    wait_done();
    step_n(4);
    chk(locked, "R10 lock reported", locked, 1);
    step_n(LOCK_TO + 50);
    chk(!lock_err, "R11 no error with lock", lock_err, 0);
    lock_det = 0;
    step_n(4);
    chk(!locked, "R10 lock follows input", locked, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset(1'b0, 1'b1);
    t_powerup();
    t_timeout();
    t_update();
    t_timing();
    t_reset(1'b1, 1'b0);
    t_lockpath();
    t_timing();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule